// File: doc/BRIEF.md
# External Bus Address Decoder

This block connects an 8-bit microcontroller's multiplexed external bus to four memory-mapped peripherals: a 32K x 8 RAM, a character LCD, a DAC that can only be written and an ADC that can only be read. During the address phase the low address byte is present on the shared address/data lines. The block holds it while the address-latch strobe is high and keeps it after the strobe falls. It joins the held byte with the high address byte to form a 16-bit address.

Only A15, A6 and A5 are decoded, so each peripheral appears at many aliased addresses. Every device has its own active-low chip enable. The DAC enable is only given during a write and the ADC enable only during a read, so neither device is ever driven in the wrong direction. On a read cycle the block returns the selected device's byte to the processor. Reads from an unmapped region or from the DAC return a fixed idle byte.

Top module: `ext_bus_decoder`

## Requirements
- R1: `ram_ce_n` is 0 exactly when address bit A15 is 1, whatever the strobes and the other address bits.
- R2: `lcd_ce_n` is 0 exactly when A15=0, A6=0 and A5=0, whatever the strobes.
- R3: `dac_ce_n` is 0 only when A15=0, A6=0, A5=1 and `wr_n` is 0. A read of that region leaves it at 1.
- R4: `adc_ce_n` is 0 only when A15=0, A6=1, A5=0 and `rd_n` is 0. A write to that region leaves it at 1.
- R5: No address and strobe combination drives more than one chip enable to 0 at the same time.
- R6: While `ale` is 1, the low address byte follows `ad_in` in the same cycle. After `ale` falls, the byte sampled at the last rising clock edge with `ale` high is held, whatever `ad_in` does afterwards.
- R7: `ram_addr` carries A[14:0] and `lcd_reg` carries A[4:0] of the current address.
- R8: `ad_oe` is 1 exactly when `rd_n` is 0 and `ale` is 0. During a read, `ad_out` equals `ram_rdata`, `lcd_rdata` or `adc_rdata` for the selected device.
- R9: When A15=0, A6=1 and A5=1, all four enables stay at 1. A read there returns the idle byte 0xFF, and so does a read of the DAC region.
- R10: Asynchronous reset clears the held low address byte to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch strobe, high during the address phase |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr_hi | input | 8 | High address byte A[15:8] |
| ad_in | input | 8 | Multiplexed low address / write data from the processor |
| ad_out | output | 8 | Read data returned to the processor |
| ad_oe | output | 1 | Read data drive enable |
| ram_rdata | input | 8 | Read data from the RAM |
| lcd_rdata | input | 8 | Read data from the LCD |
| adc_rdata | input | 8 | Read data from the ADC |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| lcd_ce_n | output | 1 | LCD chip enable, active low |
| dac_ce_n | output | 1 | DAC chip enable, active low |
| adc_ce_n | output | 1 | ADC chip enable, active low |
| ram_addr | output | 15 | RAM address A[14:0] |
| lcd_reg | output | 5 | LCD register select A[4:0] |

## Verification
The bench changes `ad_in` to an unrelated data byte right after `ale` falls. A latch that followed the bus instead of holding would then send the wrong low address to the RAM and LCD. It reads the DAC region and writes the ADC region: a decoder that ignored strobe direction would drive a one-way device backwards, and the DAC read would not return the idle byte. Aliased addresses with scattered unused bits and the unmapped A6=A5=1 hole are visited. A decoder that looked at more bits, or whose terms overlapped, would miss an alias or pull two enables low together.

// File: rtl/ext_bus_decoder.sv
module ext_bus_decoder #(
  parameter int          DW        = 8,
  parameter int          LCD_RS_W  = 5,
  parameter logic [DW-1:0] IDLE_BYTE = 8'hFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ale,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [DW-1:0]        addr_hi,
  input  logic [DW-1:0]        ad_in,
  output logic [DW-1:0]        ad_out,
  output logic                 ad_oe,
  input  logic [DW-1:0]        ram_rdata,
  input  logic [DW-1:0]        lcd_rdata,
  input  logic [DW-1:0]        adc_rdata,
  output logic                 ram_ce_n,
  output logic                 lcd_ce_n,
  output logic                 dac_ce_n,
  output logic                 adc_ce_n,
  output logic [2*DW-2:0]      ram_addr,
  output logic [LCD_RS_W-1:0]  lcd_reg
);
  localparam int AW = 2 * DW;

  logic [DW-1:0] lo_q;
  logic [DW-1:0] lo;
  logic [AW-1:0] addr;
  logic          top, b6, b5;
  logic          ram_hit, lcd_hit, dac_hit, adc_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   lo_q <= '0;
    else if (ale) lo_q <= ad_in;

  assign lo   = ale ? ad_in : lo_q;
  assign addr = {addr_hi, lo};
  assign top  = addr[AW-1];
  assign b6   = addr[6];
  assign b5   = addr[5];

  assign ram_hit = top;
  assign lcd_hit = !top && !b6 && !b5;
  assign dac_hit = !top && !b6 &&  b5;
  assign adc_hit = !top &&  b6 && !b5;

  assign ram_ce_n = !ram_hit;
  assign lcd_ce_n = !lcd_hit;
  assign dac_ce_n = !(dac_hit && !wr_n);
  assign adc_ce_n = !(adc_hit && !rd_n);

  assign ram_addr = addr[AW-2:0];
  assign lcd_reg  = addr[LCD_RS_W-1:0];

  assign ad_oe = !rd_n && !ale;

  always_comb begin
    if      (ram_hit) ad_out = ram_rdata;
    else if (lcd_hit) ad_out = lcd_rdata;
    else if (adc_hit) ad_out = adc_rdata;
    else              ad_out = IDLE_BYTE;
  end
endmodule

// File: rtl/ext_bus_decoder_chk.sv
module ext_bus_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ale,
  input logic        rd_n,
  input logic        wr_n,
  input logic [7:0]  addr_hi,
  input logic        ad_oe,
  input logic        ram_ce_n,
  input logic        lcd_ce_n,
  input logic        dac_ce_n,
  input logic        adc_ce_n,
  input logic [14:0] ram_addr
);
  assert_one_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ram_ce_n, ~lcd_ce_n, ~dac_ce_n, ~adc_ce_n}) <= 1);

  assert_dac_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_ce_n |-> !wr_n);

  assert_adc_read_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_ce_n |-> !rd_n);

  assert_ram_upper_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hi[7] |-> !ram_ce_n);

  assert_low_byte_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && $past(!ale)) |-> $stable(ram_addr[7:0]));

  assert_hole_unselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_hi[7] && ram_addr[6] && ram_addr[5]) |->
      (ram_ce_n && lcd_ce_n && dac_ce_n && adc_ce_n));

  assert_drive_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!rd_n && !ale));
endmodule

bind ext_bus_decoder ext_bus_decoder_chk i_chk (.*);

// File: tb/test_ext_bus_decoder.sv
module test_ext_bus_decoder;
  logic clk = 0, rst_n = 0, ale = 0, rd_n = 1, wr_n = 1;
  logic [7:0]  addr_hi = 0, ad_in = 0;
  logic [7:0]  ram_rdata = 8'hA1, lcd_rdata = 8'hB2, adc_rdata = 8'hC3;
  logic [7:0]  ad_out;
  logic        ad_oe, ram_ce_n, lcd_ce_n, dac_ce_n, adc_ce_n;
  logic [14:0] ram_addr;
  logic [4:0]  lcd_reg;

  int checks = 0, fails = 0;

  typedef struct {
    logic [3:0]  en_n;
    logic [14:0] ra;
    logic [4:0]  rs;
    logic        oe;
    logic [7:0]  data;
    string       req;
  } item_t;

  item_t q[$];
  event  sample_ev;

  always #2 clk = ~clk;

  ext_bus_decoder i_ext_bus_decoder (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic [7:0] hi, input logic [7:0] lo, input bit rd, input bit wr,
                        input string req);
    item_t it;
    logic [15:0] a;
    bit ram, lcd, dac, adc;
    @(negedge clk);
    ale = 1; addr_hi = hi; ad_in = lo; rd_n = 1; wr_n = 1;
    #1;
    check(ram_addr[7:0] == lo, "R6 transparent", ram_addr[7:0], lo);
    @(negedge clk);
    ale = 0; ad_in = lo ^ 8'h5A; rd_n = !rd; wr_n = !wr;
    a   = {hi, lo};
    ram = a[15];
    lcd = !a[15] && !a[6] && !a[5];
    dac = !a[15] && !a[6] &&  a[5] && wr;
    adc = !a[15] &&  a[6] && !a[5] && rd;
    it.en_n = ~{ram, lcd, dac, adc};
    it.ra   = a[14:0];
    it.rs   = a[4:0];
    it.oe   = rd;
    it.data = ram ? ram_rdata : lcd ? lcd_rdata : (adc ? adc_rdata : 8'hFF);
    it.req  = req;
    q.push_back(it);
    #1 ->sample_ev;
    @(negedge clk);
    ad_in = 8'h33;
    #1 ->sample_ev;
    q.push_back(it);
    @(negedge clk);
    rd_n = 1; wr_n = 1;
  endtask

  initial begin
    forever begin
      @(sample_ev);
      if (q.size() != 0) begin
        item_t e;
        e = q.pop_front();
        check({ram_ce_n, lcd_ce_n, dac_ce_n, adc_ce_n} == e.en_n, e.req,
              {ram_ce_n, lcd_ce_n, dac_ce_n, adc_ce_n}, e.en_n);
        check(ram_addr == e.ra, "R7 R6 ram_addr", ram_addr, e.ra);
        check(lcd_reg == e.rs, "R7 lcd_reg", lcd_reg, e.rs);
        check(ad_oe == e.oe, "R8 ad_oe", ad_oe, e.oe);
        if (e.oe) check(ad_out == e.data, "R8 R9 ad_out", ad_out, e.data);
      end
    end
  end

  initial begin
    #(200000 * 4);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    ad_in = 8'h77;
    #10;
    check(ram_addr[7:0] == 8'h00, "R10 reset low byte", ram_addr[7:0], 0);
    @(negedge clk) rst_n = 1;
    #1 check(ram_addr[7:0] == 8'h00, "R10 after reset", ram_addr[7:0], 0);

    bus_op(8'h80, 8'h00, 1, 0, "R1 ram read low");
    bus_op(8'hFF, 8'hFF, 0, 1, "R1 ram write top");
    bus_op(8'hC3, 8'h65, 1, 0, "R1 ram alias");
    bus_op(8'h00, 8'h00, 1, 0, "R2 lcd read 0");
    bus_op(8'h00, 8'h1F, 0, 1, "R2 lcd write 31");
    bus_op(8'h5A, 8'h9E, 1, 0, "R2 lcd alias");
    bus_op(8'h00, 8'h20, 0, 1, "R3 dac write 32");
    bus_op(8'h00, 8'h20, 1, 0, "R3 R9 dac read blocked");
    bus_op(8'h7F, 8'hBF, 0, 1, "R3 dac alias");
    bus_op(8'h00, 8'h40, 1, 0, "R4 adc read 64");
    bus_op(8'h00, 8'h40, 0, 1, "R4 adc write blocked");
    bus_op(8'h21, 8'hD3, 1, 0, "R4 adc alias");
    bus_op(8'h00, 8'h60, 1, 0, "R9 hole read");
    bus_op(8'h4C, 8'hF1, 0, 1, "R9 hole write");
    bus_op(8'h00, 8'h20, 0, 0, "R5 R3 dac idle");
    for (int i = 0; i < 16; i++)
      bus_op(8'(i * 37), 8'(i * 53 + 11), i[0], !i[0], "R5 sweep");

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule